// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. It presents a trial code to the DAC on each ADC clock. It takes back one comparator decision per step and builds the result from the most significant bit downward. It also steers the input multiplexer, opens the sampling window, and decides when the next conversion runs. A conversion can run once, repeat without a gap, or sweep a range of channels. Results can also be kept in one storage slot per channel.

The ADC clock is a clock enable produced from the system clock by a programmable divider. Each conversion takes fourteen of these enables: one to synchronise, three to sample and ten bit decisions. A new conversion can be requested by a software pulse, a timer event or the rising edge of an external trigger pin. The timer and pin sources each have their own enable. The latest result is shown as a 16-bit word with the 10 data bits at either end. In buffered mode each result also goes into a per-slot register that carries a valid bit. The block keeps sticky flags for completion, buffer overwrite and out-of-window values. It combines the completion and window flags into one interrupt line.

Top module: `sar_seq_top`

## Requirements
- R1: One ADC tick occurs every D system clocks, where D is `div_sel` limited to the range 2 to 18; a value below 2 acts as 2 and a value above 18 acts as 18.
- R2: After `adc_en` rises, no conversion starts until `stab_ticks` ADC ticks have elapsed. Start requests that arrive during this wait are discarded.
- R3: A conversion lasts exactly 14 ticks: 1 synchronisation tick, then 3 ticks with `sample_o` high and `dac_code` zero, then 10 bit-decision ticks. From a software start to `eoc` rising takes between 14·D+1 and 15·D system clocks.
- R4: `cmp_in` is 1 when the analog input is at or above `dac_code`. The stored result is the largest 10-bit code that the comparator accepts.
- R5: In single mode (`mode_cont`=0, `mode_scan`=0), exactly one conversion runs per start request.
- R6: In continuous mode the next conversion starts on the tick after the previous one completes, so successive results are exactly 14·D system clocks apart.
- R7: In scan mode the multiplexer visits channels 0, 1, … up to `last_chan` in that order. Each result is stored in the buffer slot with the same number. `eoc` is raised only after the last channel has been converted.
- R8: `align_left`=0 puts the 10-bit value in bits 9:0 of `data_word` and `buf_word` with zeros above. `align_left`=1 puts it in bits 15:6 with zeros below.
- R9: In buffered mode each result sets the valid bit of its slot. A pulse on `buf_rd_hi` (reading the upper byte) clears the valid bit of slot `buf_idx`. Writing a slot whose valid bit is still set raises `ovr`, which stays set until `ovr_clr`. Without scan, the slot number advances after each result and wraps to 0 after `last_chan`.
- R10: A start is requested by `sw_start`, by `tmr_trig` when `tmr_en`=1, or by a rising edge of `ext_trig` when `ext_en`=1. Disabled sources have no effect, and requests that arrive while a conversion or sequence is running are discarded.
- R11: `eoc` is set when a result (or a full scan) completes and holds until `eoc_clr`. Reset clears it.
- R12: `awd` is set when a result is strictly above `thr_hi` or strictly below `thr_lo`; a value equal to a threshold does not set it. It holds until `awd_clr`.
- R13: `irq` is high when (`eoc` and `eoc_ie`) or (`awd` and `awd_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_en | input | 1 | Converter power-on enable; low aborts and idles |
| div_sel | input | 5 | ADC tick divider, clamped to 2..18 |
| stab_ticks | input | 8 | Stabilisation wait in ADC ticks |
| mode_cont | input | 1 | Continuous repetition |
| mode_scan | input | 1 | Channel sweep from 0 to last_chan |
| mode_buf | input | 1 | Store results into slot registers |
| chan_sel | input | 4 | Channel converted outside scan |
| last_chan | input | 4 | Final channel of a scan / slot wrap point |
| align_left | input | 1 | Result placement in 16-bit words |
| sw_start | input | 1 | Software start pulse |
| tmr_trig | input | 1 | Timer event pulse |
| tmr_en | input | 1 | Accept timer events |
| ext_trig | input | 1 | External trigger pin, rising-edge sensitive |
| ext_en | input | 1 | Accept external trigger |
| eoc_clr | input | 1 | Clear completion flag |
| ovr_clr | input | 1 | Clear overrun flag |
| awd_clr | input | 1 | Clear window flag |
| eoc_ie | input | 1 | Completion interrupt enable |
| awd_ie | input | 1 | Window interrupt enable |
| thr_hi | input | 10 | Upper window limit |
| thr_lo | input | 10 | Lower window limit |
| buf_idx | input | 4 | Slot selected for reading |
| buf_rd_hi | input | 1 | Upper-byte read strobe for slot buf_idx |
| cmp_in | input | 1 | Comparator decision |
| dac_code | output | 10 | Trial code for the DAC |
| sample_o | output | 1 | Sampling switch closed |
| mux_ch | output | 4 | Analog multiplexer select |
| data_word | output | 16 | Latest result, aligned |
| buf_word | output | 16 | Slot buf_idx contents, aligned |
| buf_valid | output | 16 | Per-slot unread flags |
| eoc | output | 1 | Completion flag |
| ovr | output | 1 | Buffer overrun flag |
| awd | output | 1 | Window violation flag |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded properties assume that mode bits, `chan_sel`, `last_chan` and `div_sel` stay still while a conversion is in flight. They also assume that `cmp_in` is a settled function of `dac_code` and `mux_ch` within the same cycle, and that `buf_idx` names an existing slot. The stimulus changes configuration only while the sequencer is idle or disabled. It derives the comparator from a per-channel target value, so every result the bench expects is the target itself. The clear and read strobes are single-cycle pulses given at falling clock edges.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_STAB = 2'd1,
    ST_IDLE = 2'd2,
    ST_BUSY = 2'd3
  } seq_st_e;

  localparam int SYNC_TICKS = 1;
  localparam int SAMP_TICKS = 3;

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int DIVW    = 5,
  parameter int DIV_MIN = 2,
  parameter int DIV_MAX = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div_sel,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q, cnt_d, div_m1;

  always_comb begin
    if (div_sel < DIVW'(DIV_MIN))
      div_m1 = DIVW'(DIV_MIN - 1);
    else if (div_sel > DIVW'(DIV_MAX))
      div_m1 = DIVW'(DIV_MAX - 1);
    else
      div_m1 = div_sel - 1'b1;
    tick = run && (cnt_q >= div_m1);
    if (!run || tick)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int RES   = 10,
  parameter int CHW   = 4,
  parameter int STABW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             start_evt,
  input  logic             cont,
  input  logic             scan,
  input  logic             bufm,
  input  logic [CHW-1:0]   chan_sel,
  input  logic [CHW-1:0]   last_chan,
  input  logic [STABW-1:0] stab_ticks,
  input  logic             cmp_in,
  output logic [RES-1:0]   dac_code,
  output logic             sample,
  output logic [CHW-1:0]   mux_ch,
  output logic             done,
  output logic [RES-1:0]   done_val,
  output logic [CHW-1:0]   done_slot,
  output logic             done_eoc
);

  localparam int NPH   = SYNC_TICKS + SAMP_TICKS + RES;
  localparam int PHW   = $clog2(NPH);
  localparam logic [PHW-1:0] PH_SAMP0 = PHW'(SYNC_TICKS);
  localparam logic [PHW-1:0] PH_CONV0 = PHW'(SYNC_TICKS + SAMP_TICKS);
  localparam logic [PHW-1:0] PH_LAST  = PHW'(NPH - 1);
  localparam logic [PHW-1:0] MSB_POS  = PHW'(RES - 1);

  seq_st_e          st_q, st_d;
  logic [PHW-1:0]   ph_q, ph_d;
  logic [RES-1:0]   sar_q, sar_d;
  logic [CHW-1:0]   slot_q, slot_d;
  logic [STABW-1:0] stab_q, stab_d;
  logic             pend_q, pend_d;

  logic             conv_ph, slot_last, restart;
  logic [PHW-1:0]   step;
  logic [RES-1:0]   mask, trial;

  // datapath decode
  always_comb begin
    conv_ph   = (st_q == ST_BUSY) && (ph_q >= PH_CONV0);
    step      = ph_q - PH_CONV0;
    mask      = conv_ph ? (RES'(1) << (MSB_POS - step)) : '0;
    trial     = sar_q | mask;
    dac_code  = conv_ph ? trial : '0;
    sample    = (st_q == ST_BUSY) && (ph_q >= PH_SAMP0) && (ph_q < PH_CONV0);
    mux_ch    = scan ? slot_q : chan_sel;
    slot_last = (slot_q == last_chan);
    restart   = cont || (scan && !slot_last);
    done      = en && (st_q == ST_BUSY) && tick && (ph_q == PH_LAST);
    done_val  = cmp_in ? trial : sar_q;
    done_slot = slot_q;
    done_eoc  = !scan || slot_last;
  end

  // next state
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    sar_d  = sar_q;
    slot_d = slot_q;
    stab_d = stab_q;
    pend_d = 1'b0;
    if (!en) begin
      st_d   = ST_OFF;
      ph_d   = '0;
      sar_d  = '0;
      slot_d = '0;
      stab_d = '0;
    end else begin
      case (st_q)
        ST_OFF: begin
          st_d   = ST_STAB;
          stab_d = '0;
        end
        ST_STAB: begin
          if (tick) begin
            if (({1'b0, stab_q} + 1'b1) >= {1'b0, stab_ticks})
              st_d = ST_IDLE;
            else
              stab_d = stab_q + 1'b1;
          end
        end
        ST_IDLE: begin
          pend_d = pend_q | start_evt;
          if (tick && pend_q) begin
            st_d   = ST_BUSY;
            ph_d   = '0;
            sar_d  = '0;
            pend_d = 1'b0;
            if (scan) slot_d = '0;
          end
        end
        ST_BUSY: begin
          if (tick) begin
            if (conv_ph && cmp_in) sar_d = trial;
            if (ph_q == PH_LAST) begin
              if (scan || bufm)
                slot_d = slot_last ? '0 : slot_q + 1'b1;
              if (restart) begin
                ph_d  = '0;
                sar_d = '0;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      ph_q   <= '0;
      sar_q  <= '0;
      slot_q <= '0;
      stab_q <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      sar_q  <= sar_d;
      slot_q <= slot_d;
      stab_q <= stab_d;
      pend_q <= pend_d;
    end
  end

  AST_STAB_NO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STAB) |=> (st_q != ST_BUSY)); // R2
  AST_SAMPLE_NO_DAC: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (dac_code == '0)); // R3
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (st_q == ST_BUSY) && tick && (ph_q != PH_LAST)) |=> (ph_q == $past(ph_q) + 1'b1)); // R3

endmodule

// File: rtl/sar_store.sv
module sar_store #(
  parameter int RES  = 10,
  parameter int NCH  = 16,
  parameter int CHW  = 4,
  parameter int WORD = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic [RES-1:0]  done_val,
  input  logic [CHW-1:0]  done_slot,
  input  logic            done_eoc,
  input  logic            bufm,
  input  logic            align_left,
  input  logic            eoc_clr,
  input  logic            ovr_clr,
  input  logic            awd_clr,
  input  logic [RES-1:0]  thr_hi,
  input  logic [RES-1:0]  thr_lo,
  input  logic [CHW-1:0]  buf_idx,
  input  logic            buf_rd_hi,
  output logic [WORD-1:0] data_word,
  output logic [WORD-1:0] buf_word,
  output logic [NCH-1:0]  buf_valid,
  output logic            eoc,
  output logic            ovr,
  output logic            awd
);

  localparam int PAD = WORD - RES;

  function automatic logic [WORD-1:0] place(input logic [RES-1:0] v, input logic left);
    place = left ? {v, {PAD{1'b0}}} : {{PAD{1'b0}}, v};
  endfunction

  logic [RES-1:0] last_q, last_d;
  logic [RES-1:0] slot_q [NCH];
  logic [NCH-1:0] valid_q, valid_d;
  logic           eoc_q, eoc_d, ovr_q, ovr_d, awd_q, awd_d;
  logic           wr_buf, out_win;

  always_comb begin
    wr_buf  = done && bufm;
    out_win = (done_val > thr_hi) || (done_val < thr_lo);
    last_d  = done ? done_val : last_q;
    valid_d = valid_q;
    if (buf_rd_hi) valid_d[buf_idx]   = 1'b0;
    if (wr_buf)    valid_d[done_slot] = 1'b1;
    eoc_d = (done && done_eoc) || (eoc_q && !eoc_clr);
    ovr_d = (wr_buf && valid_q[done_slot]) || (ovr_q && !ovr_clr);
    awd_d = (done && out_win) || (awd_q && !awd_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      valid_q <= '0;
      eoc_q   <= 1'b0;
      ovr_q   <= 1'b0;
      awd_q   <= 1'b0;
    end else begin
      last_q  <= last_d;
      valid_q <= valid_d;
      eoc_q   <= eoc_d;
      ovr_q   <= ovr_d;
      awd_q   <= awd_d;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[i] <= '0;
      else if (wr_buf && (done_slot == CHW'(i)))
        slot_q[i] <= done_val;
    end
  end

  assign data_word = place(last_q, align_left);
  assign buf_word  = place(slot_q[buf_idx], align_left);
  assign buf_valid = valid_q;
  assign eoc       = eoc_q;
  assign ovr       = ovr_q;
  assign awd       = awd_q;

  AST_EOC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !eoc_clr) |=> eoc); // R11
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr); // R9
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bufm) |=> buf_valid[$past(done_slot)]); // R9
  AST_AWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (awd && !awd_clr) |=> awd); // R12

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int RES   = 10,
  parameter int NCH   = 16,
  parameter int CHW   = $clog2(NCH),
  parameter int DIVW  = 5,
  parameter int STABW = 8,
  parameter int WORD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_en,
  input  logic [DIVW-1:0]  div_sel,
  input  logic [STABW-1:0] stab_ticks,
  input  logic             mode_cont,
  input  logic             mode_scan,
  input  logic             mode_buf,
  input  logic [CHW-1:0]   chan_sel,
  input  logic [CHW-1:0]   last_chan,
  input  logic             align_left,
  input  logic             sw_start,
  input  logic             tmr_trig,
  input  logic             tmr_en,
  input  logic             ext_trig,
  input  logic             ext_en,
  input  logic             eoc_clr,
  input  logic             ovr_clr,
  input  logic             awd_clr,
  input  logic             eoc_ie,
  input  logic             awd_ie,
  input  logic [RES-1:0]   thr_hi,
  input  logic [RES-1:0]   thr_lo,
  input  logic [CHW-1:0]   buf_idx,
  input  logic             buf_rd_hi,
  input  logic             cmp_in,
  output logic [RES-1:0]   dac_code,
  output logic             sample_o,
  output logic [CHW-1:0]   mux_ch,
  output logic [WORD-1:0]  data_word,
  output logic [WORD-1:0]  buf_word,
  output logic [NCH-1:0]   buf_valid,
  output logic             eoc,
  output logic             ovr,
  output logic             awd,
  output logic             irq
);

  logic           tick, start_evt, ext_q;
  logic           done, done_eoc;
  logic [RES-1:0] done_val;
  logic [CHW-1:0] done_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  assign start_evt = sw_start || (tmr_en && tmr_trig) || (ext_en && ext_trig && !ext_q);
  assign irq       = (eoc && eoc_ie) || (awd && awd_ie);

  sar_clkdiv #(.DIVW(DIVW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (adc_en),
    .div_sel (div_sel),
    .tick    (tick)
  );

  sar_ctrl #(.RES(RES), .CHW(CHW), .STABW(STABW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (adc_en),
    .tick       (tick),
    .start_evt  (start_evt),
    .cont       (mode_cont),
    .scan       (mode_scan),
    .bufm       (mode_buf),
    .chan_sel   (chan_sel),
    .last_chan  (last_chan),
    .stab_ticks (stab_ticks),
    .cmp_in     (cmp_in),
    .dac_code   (dac_code),
    .sample     (sample_o),
    .mux_ch     (mux_ch),
    .done       (done),
    .done_val   (done_val),
    .done_slot  (done_slot),
    .done_eoc   (done_eoc)
  );

  sar_store #(.RES(RES), .NCH(NCH), .CHW(CHW), .WORD(WORD)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .done_val   (done_val),
    .done_slot  (done_slot),
    .done_eoc   (done_eoc),
    .bufm       (mode_buf),
    .align_left (align_left),
    .eoc_clr    (eoc_clr),
    .ovr_clr    (ovr_clr),
    .awd_clr    (awd_clr),
    .thr_hi     (thr_hi),
    .thr_lo     (thr_lo),
    .buf_idx    (buf_idx),
    .buf_rd_hi  (buf_rd_hi),
    .data_word  (data_word),
    .buf_word   (buf_word),
    .buf_valid  (buf_valid),
    .eoc        (eoc),
    .ovr        (ovr),
    .awd        (awd)
  );

endmodule

// File: tb/tb_sar_seq_top.sv
module tb_sar_seq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adc_en;
  logic [4:0]  div_sel;
  logic [7:0]  stab_ticks;
  logic        mode_cont, mode_scan, mode_buf;
  logic [3:0]  chan_sel, last_chan;
  logic        align_left;
  logic        sw_start, tmr_trig, tmr_en, ext_trig, ext_en;
  logic        eoc_clr, ovr_clr, awd_clr, eoc_ie, awd_ie;
  logic [9:0]  thr_hi, thr_lo;
  logic [3:0]  buf_idx;
  logic        buf_rd_hi;
  logic        cmp_in;
  logic [9:0]  dac_code;
  logic        sample_o;
  logic [3:0]  mux_ch;
  logic [15:0] data_word, buf_word, buf_valid;
  logic        eoc, ovr, awd, irq;

  logic [9:0]  tgt [16];
  logic [15:0] exp_q [$];
  int checks = 0, errors = 0, cyc = 0;
  int ev_cnt = 0, ev_time = 0, prev_time = 0, last_gap = 0, samp_cnt = 0;
  int t0 = 0;
  bit hold = 1'b0, seen = 1'b0;

  always #4 clk = ~clk;

  assign cmp_in = (tgt[mux_ch] >= dac_code);

  sar_seq_top dut (.*);

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (sample_o) samp_cnt <= samp_cnt + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // monitor: pops expected result words as completions appear, clears eoc
  initial begin
    logic [15:0] w;
    eoc_clr = 1'b0;
    forever begin
      @(negedge clk);
      if (eoc && !seen) begin
        seen      = 1'b1;
        prev_time = ev_time;
        ev_time   = cyc;
        last_gap  = ev_time - prev_time;
        ev_cnt++;
        if (exp_q.size() == 0)
          chk(1'b0, "R4 unexpected result", int'(data_word), 0);
        else begin
          w = exp_q.pop_front();
          chk(data_word == w, "R4 result word", int'(data_word), int'(w));
        end
      end
      eoc_clr = eoc && seen && !hold;
      if (!eoc) seen = 1'b0;
    end
  end

  task automatic pulse_sw();
    @(negedge clk); sw_start = 1'b1; t0 = cyc;
    @(negedge clk); sw_start = 1'b0;
  endtask

  task automatic wait_ev(input int n);
    int goal = ev_cnt + n;
    int guard = 0;
    while (ev_cnt < goal && guard < 20000) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);
    if (ev_cnt < goal) chk(1'b0, "completion timeout", ev_cnt, goal);
  endtask

  task automatic run_one(input logic [15:0] w);
    exp_q.push_back(w);
    pulse_sw();
    wait_ev(1);
  endtask

  task automatic lat_chk(input int d, input int convs, input string r);
    int l = ev_time - (t0 + 1);
    chk(l >= 14*convs*d + 1 && l <= 14*convs*d + d, r, l, 14*convs*d + 1);
  endtask

  task automatic rd_buf(input int i, output logic [15:0] v);
    @(negedge clk); buf_idx = 4'(i); #1; v = buf_word;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0, s0;
    logic [15:0] v;
    rst_n = 1'b0; adc_en = 1'b0; div_sel = 5'd2; stab_ticks = 8'd20;
    mode_cont = 0; mode_scan = 0; mode_buf = 0; chan_sel = 4'd3; last_chan = 4'd0;
    align_left = 0; sw_start = 0; tmr_trig = 0; tmr_en = 0; ext_trig = 0; ext_en = 0;
    ovr_clr = 0; awd_clr = 0; eoc_ie = 0; awd_ie = 0;
    thr_hi = 10'h3FF; thr_lo = 10'h000; buf_idx = 0; buf_rd_hi = 0;
    for (int i = 0; i < 16; i++) tgt[i] = 10'(i * 37);
    repeat (5) @(negedge clk);
    chk(eoc == 0 && ovr == 0 && awd == 0 && irq == 0, "R11 reset flags", {eoc, ovr, awd, irq}, 0);
    chk(data_word == 0 && buf_valid == 0 && dac_code == 0 && sample_o == 0, "R8 reset outputs",
        int'(data_word), 0);
    rst_n = 1'b1;

    // R2: start during stabilisation is dropped
    @(negedge clk); adc_en = 1'b1;
    repeat (3) @(negedge clk);
    pulse_sw();
    repeat (60) @(negedge clk);
    chk(ev_cnt == 0 && samp_cnt == 0, "R2 start during stabilisation", ev_cnt, 0);
    repeat (10) @(negedge clk);

    // R3 R4 R5 single conversion, right aligned
    tgt[3] = 10'h2A5; s0 = samp_cnt;
    run_one(16'h02A5);
    lat_chk(2, 1, "R3 latency");
    chk(samp_cnt - s0 == 6, "R3 sample window", samp_cnt - s0, 6);
    n0 = ev_cnt; s0 = samp_cnt;
    repeat (100) @(negedge clk);
    chk(ev_cnt == n0 && samp_cnt == s0, "R5 single mode stops", ev_cnt, n0);

    // R8 alignment and code extremes
    align_left = 1'b1; tgt[3] = 10'h3FF;
    run_one(16'hFFC0);
    tgt[3] = 10'h000;
    run_one(16'h0000);
    align_left = 1'b0; chan_sel = 4'd7; tgt[7] = 10'h001;
    run_one(16'h0001);

    // R10 trigger sources
    n0 = ev_cnt;
    @(negedge clk); tmr_trig = 1; @(negedge clk); tmr_trig = 0;
    repeat (80) @(negedge clk);
    chk(ev_cnt == n0, "R10 timer disabled", ev_cnt, n0);
    tmr_en = 1; tgt[7] = 10'h155; exp_q.push_back(16'h0155);
    @(negedge clk); tmr_trig = 1; t0 = cyc; @(negedge clk); tmr_trig = 0;
    wait_ev(1);
    chk(ev_cnt == n0 + 1, "R10 timer enabled", ev_cnt, n0 + 1);
    tmr_en = 0;
    n0 = ev_cnt;
    @(negedge clk); ext_trig = 1; repeat (80) @(negedge clk); ext_trig = 0;
    chk(ev_cnt == n0, "R10 external disabled", ev_cnt, n0);
    repeat (2) @(negedge clk); ext_en = 1; exp_q.push_back(16'h0155);
    @(negedge clk); ext_trig = 1; t0 = cyc;
    wait_ev(1);
    repeat (80) @(negedge clk);
    chk(ev_cnt == n0 + 1, "R10 external edge once", ev_cnt, n0 + 1);
    ext_trig = 0; ext_en = 0;

    // R10 request during busy is dropped
    n0 = ev_cnt; exp_q.push_back(16'h0155);
    pulse_sw();
    repeat (10) @(negedge clk);
    sw_start = 1; @(negedge clk); sw_start = 0;
    wait_ev(1);
    repeat (80) @(negedge clk);
    chk(ev_cnt == n0 + 1, "R10 start while busy", ev_cnt, n0 + 1);

    // R12 R13 window
    thr_hi = 10'h300; thr_lo = 10'h100; awd_ie = 1;
    tgt[7] = 10'h300; run_one(16'h0300);
    chk(awd == 0 && irq == 0, "R12 equal to high limit", awd, 0);
    tgt[7] = 10'h301; run_one(16'h0301);
    chk(awd == 1, "R12 above high limit", awd, 1);
    chk(irq == 1, "R13 window interrupt", irq, 1);
    @(negedge clk); awd_clr = 1; @(negedge clk); awd_clr = 0;
    chk(awd == 0 && irq == 0, "R12 clear", awd, 0);
    tgt[7] = 10'h100; run_one(16'h0100);
    chk(awd == 0, "R12 equal to low limit", awd, 0);
    tgt[7] = 10'h0FF; run_one(16'h00FF);
    chk(awd == 1, "R12 below low limit", awd, 1);
    @(negedge clk); awd_clr = 1; @(negedge clk); awd_clr = 0;
    awd_ie = 0; thr_hi = 10'h3FF; thr_lo = 10'h000;
    hold = 1; eoc_ie = 1; tgt[7] = 10'h0AA; run_one(16'h00AA);
    repeat (5) @(negedge clk);
    chk(eoc == 1, "R11 flag holds without clear", eoc, 1);
    chk(irq == 1, "R13 completion interrupt", irq, 1);
    hold = 0; repeat (3) @(negedge clk);
    chk(eoc == 0 && irq == 0, "R11 cleared", eoc, 0);
    eoc_ie = 0;

    // R7 R8 R9 scan into slots
    mode_scan = 1; mode_buf = 1; last_chan = 4'd3;
    tgt[0] = 10'h011; tgt[1] = 10'h122; tgt[2] = 10'h233; tgt[3] = 10'h344;
    run_one(16'h0344);
    lat_chk(2, 4, "R7 single completion after sweep");
    chk(buf_valid == 16'h000F, "R9 valid after sweep", int'(buf_valid), 16'h000F);
    for (int i = 0; i < 4; i++) begin
      rd_buf(i, v);
      chk(v == {6'b0, tgt[i]}, "R7 slot contents", int'(v), int'(tgt[i]));
    end
    align_left = 1; rd_buf(1, v);
    chk(v == {tgt[1], 6'b0}, "R8 slot left aligned", int'(v), int'({tgt[1], 6'b0}));
    align_left = 0;
    chk(ovr == 0, "R9 no overrun yet", ovr, 0);
    run_one(16'h0344);
    chk(ovr == 1, "R9 overrun on unread slot", ovr, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); buf_idx = 4'(i); buf_rd_hi = 1;
      @(negedge clk); buf_rd_hi = 0;
    end
    chk(buf_valid == 0, "R9 upper read clears valid", int'(buf_valid), 0);
    chk(ovr == 1, "R9 overrun sticky", ovr, 1);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    chk(ovr == 0, "R9 overrun cleared", ovr, 0);

    // R6 R9 continuous buffered without scan
    mode_scan = 0; last_chan = 4'd1; mode_cont = 1; chan_sel = 4'd2; tgt[2] = 10'h155;
    repeat (3) exp_q.push_back(16'h0155);
    pulse_sw();
    wait_ev(3);
    adc_en = 0;
    chk(last_gap == 28, "R6 back-to-back spacing", last_gap, 28);
    chk(buf_valid == 16'h0003, "R9 slot wrap", int'(buf_valid), 3);
    chk(ovr == 1, "R9 overrun after wrap", ovr, 1);
    n0 = ev_cnt; repeat (60) @(negedge clk);
    chk(ev_cnt == n0, "R6 disable stops repetition", ev_cnt, n0);
    @(negedge clk); ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    mode_cont = 0; mode_buf = 0; last_chan = 0;

    // R1 divider clamp
    stab_ticks = 8'd2; div_sel = 5'd1; chan_sel = 4'd9; tgt[9] = 10'h1C3;
    @(negedge clk); adc_en = 1; repeat (20) @(negedge clk);
    run_one(16'h01C3); lat_chk(2, 1, "R1 divider low clamp");
    div_sel = 5'd5; run_one(16'h01C3); lat_chk(5, 1, "R1 divider five");
    div_sel = 5'd31; run_one(16'h01C3); lat_chk(18, 1, "R1 divider high clamp");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule